// File: doc/BRIEF.md
# Push-Pull PWM Latch and Steering Core

This block is the digital core of a double-ended, fixed-frequency pulse width modulator. A counter produces a sawtooth period made of a long ramp-up interval followed by a short blanking interval. In every period one of two drive outputs, A or B, may be on. The two outputs take turns from one period to the next, so each runs at half the period rate. Neither can exceed the ramp-up share of its own period.

A drive pulse begins after blanking. It ends when the digitized ramp sample, plus a fixed offset, rises above the error code, or when the current-limit flag is raised. The end-of-pulse event is held in a set-only latch that only the next blanking can clear, so a period never carries two pulses. A fault sequencer gates the outputs through an enable input. In slave mode, an external sync pulse clears the latch and blanks the outputs without touching the period counter. In master mode a clock output marks each blanking interval. All comparisons are made on digital codes.

Top module: `pp_pwm_core`

## Requirements
- R1: After reset release, `clk_o` is high in cycle n (n = rising edges since release) exactly when n mod (C+B) >= C. C is the ramp length `chg_len_i` and B is the blank length `blk_len_i`, both in cycles.
- R2: In the cycle after any blanking cycle (`clk_o` high), both outputs are low, and the terminate latch is clear.
- R3: Steering starts on output A after reset. It toggles on each rising edge of the blanking condition while enabled, so consecutive periods drive A and B in turn.
- R4: A pulse ends one cycle after `ramp_code_i + RAMP_OFS > err_code_i`, with unsigned codes and default RAMP_OFS = 32. If the error code is below the offset, no pulse occurs.
- R5: When `ilim_i` is high, the output is low on the next cycle, and the latch is set for the rest of the ramp interval.
- R6: Once a pulse has ended, the outputs stay low until the next blanking, even if the ramp falls back or the limit flag clears.
- R7: With `slave_i` = 1, a high `sync_i` forces both outputs low on the next cycle, clears the latch and toggles steering on its rising edge. The period counter and `clk_o` are unaffected.
- R8: With `slave_i` = 0, `sync_i` has no effect on the outputs or on steering.
- R9: While `en_i` is low, both outputs are low on the next cycle and the steering state holds.
- R10: A length of zero on `chg_len_i` or `blk_len_i` acts as a length of one.
- R11: `out_a_o` and `out_b_o` are never high in the same cycle.
- R12: During reset, `out_a_o`, `out_b_o` and `clk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Drive enable from fault sequencer |
| slave_i | input | 1 | 1: honour external sync |
| sync_i | input | 1 | External clock/sync pulse |
| chg_len_i | input | CNT_W | Ramp-up interval length in cycles |
| blk_len_i | input | CNT_W | Blanking interval length in cycles |
| err_code_i | input | CODE_W | Error threshold code |
| ramp_code_i | input | CODE_W | Digitized ramp sample |
| ilim_i | input | 1 | Cycle-by-cycle current-limit flag |
| out_a_o | output | 1 | Drive output A (registered) |
| out_b_o | output | 1 | Drive output B (registered) |
| clk_o | output | 1 | High during blanking |

## Verification
The properties assume that the inputs are synchronous to `clk_i` and change only away from its rising edge. They also assume that the length inputs stay constant between resets. The bench changes every input just after a falling edge, and it changes the ramp and blank lengths only while reset is held. It then sweeps error codes, ramp slopes, limit pulses, sync pulses, enable gaps and zero lengths against its own arithmetic model of the period position.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

  typedef enum logic {
    PH_RAMP  = 1'b0,
    PH_BLANK = 1'b1
  } phase_e;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } steer_e;

  localparam int unsigned NUM_OUT = 2;

endpackage

// File: rtl/pp_pwm_ramp_timer.sv
module pp_pwm_ramp_timer
  import pp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] chg_len_i,
  input  logic [CNT_W-1:0] blk_len_i,
  output logic             blank_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] chg_eff, blk_eff, len_cur;
  logic             last;

  // zero length would stall the period; treat as one
  assign chg_eff = (chg_len_i == '0) ? ONE : chg_len_i;
  assign blk_eff = (blk_len_i == '0) ? ONE : blk_len_i;
  assign len_cur = (ph_q == PH_RAMP) ? chg_eff : blk_eff;
  assign last    = (cnt_q >= (len_cur - ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_RAMP;
      cnt_q <= '0;
    end else if (last) begin
      cnt_q <= '0;
      ph_q  <= (ph_q == PH_RAMP) ? PH_BLANK : PH_RAMP;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign blank_o = (ph_q == PH_BLANK);

endmodule

// File: rtl/pp_pwm_term_latch.sv
module pp_pwm_term_latch #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned RAMP_OFS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic [CODE_W-1:0] ramp_code_i,
  input  logic              ilim_i,
  input  logic              blank_i,
  output logic              trip_o,
  output logic              latch_o
);

  localparam int unsigned    SUM_W = CODE_W + 1;
  localparam logic [SUM_W-1:0] OFS = SUM_W'(RAMP_OFS);

  logic [SUM_W-1:0] ramp_ofs;
  logic             cmp_hit;
  logic             latch_q;

  // ramp > err - ofs, rewritten without underflow
  assign ramp_ofs = {1'b0, ramp_code_i} + OFS;
  assign cmp_hit  = (ramp_ofs > {1'b0, err_code_i});
  assign trip_o   = cmp_hit | ilim_i;

  // blanking dominates set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_q <= 1'b0;
    else if (blank_i) latch_q <= 1'b0;
    else if (trip_o)  latch_q <= 1'b1;
  end

  assign latch_o = latch_q;

endmodule

// File: rtl/pp_pwm_steer.sv
module pp_pwm_steer
  import pp_pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               blank_i,
  input  logic               trip_i,
  input  logic               latch_i,
  output logic [NUM_OUT-1:0] drv_o
);

  steer_e             steer_q;
  logic               blank_prev_q;
  logic               active;
  logic [NUM_OUT-1:0] drv_q;

  assign active = en_i & ~blank_i & ~latch_i & ~trip_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_q      <= SEL_A;
      blank_prev_q <= 1'b0;
    end else begin
      blank_prev_q <= blank_i;
      if (en_i && blank_i && !blank_prev_q)
        steer_q <= (steer_q == SEL_A) ? SEL_B : SEL_A;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_drv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) drv_q[g] <= 1'b0;
      else         drv_q[g] <= active && (int'(steer_q) == g);
    end
  end

  assign drv_o = drv_q;

endmodule

// File: rtl/pp_pwm_core.sv
module pp_pwm_core
  import pp_pwm_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned RAMP_OFS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              slave_i,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  chg_len_i,
  input  logic [CNT_W-1:0]  blk_len_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic [CODE_W-1:0] ramp_code_i,
  input  logic              ilim_i,
  output logic              out_a_o,
  output logic              out_b_o,
  output logic              clk_o
);

  logic               blank_int;
  logic               blank_eff;
  logic               trip;
  logic               latch;
  logic [NUM_OUT-1:0] drv;

  pp_pwm_ramp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chg_len_i (chg_len_i),
    .blk_len_i (blk_len_i),
    .blank_o   (blank_int)
  );

  // slave sync blanks without restarting the timer
  assign blank_eff = blank_int | (slave_i & sync_i);

  pp_pwm_term_latch #(.CODE_W(CODE_W), .RAMP_OFS(RAMP_OFS)) u_term (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_code_i  (err_code_i),
    .ramp_code_i (ramp_code_i),
    .ilim_i      (ilim_i),
    .blank_i     (blank_eff),
    .trip_o      (trip),
    .latch_o     (latch)
  );

  pp_pwm_steer u_steer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .blank_i (blank_eff),
    .trip_i  (trip),
    .latch_i (latch),
    .drv_o   (drv)
  );

  assign out_a_o = drv[0];
  assign out_b_o = drv[1];
  assign clk_o   = blank_int;

endmodule

// File: rtl/pp_pwm_core_chk.sv
module pp_pwm_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic slave_i,
  input logic sync_i,
  input logic ilim_i,
  input logic out_a_o,
  input logic out_b_o,
  input logic clk_o
);

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_a_o && out_b_o));

  p_blank_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o |=> (!out_a_o && !out_b_o));

  p_ilim_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_i |=> (!out_a_o && !out_b_o));

  p_sync_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i && sync_i) |=> (!out_a_o && !out_b_o));

  p_en_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!out_a_o && !out_b_o));

  p_one_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(out_a_o) && !clk_o) |=> !out_a_o);

endmodule

bind pp_pwm_core pp_pwm_core_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .slave_i (slave_i),
  .sync_i  (sync_i),
  .ilim_i  (ilim_i),
  .out_a_o (out_a_o),
  .out_b_o (out_b_o),
  .clk_o   (clk_o)
);

// File: tb/pp_pwm_core_tb.sv
module pp_pwm_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OFS        = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       slave_i = 1'b0;
  logic       sync_i = 1'b0;
  logic [7:0] chg_len_i = 8'd9;
  logic [7:0] blk_len_i = 8'd1;
  logic [7:0] err_code_i = 8'd255;
  logic [7:0] ramp_code_i = 8'd0;
  logic       ilim_i = 1'b0;
  logic       out_a_o, out_b_o, clk_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc, cp, bp;
  bit m_latch, m_steer, m_prev;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pp_pwm_core u_dut (
    .clk_i, .rst_ni, .en_i, .slave_i, .sync_i, .chg_len_i, .blk_len_i,
    .err_code_i, .ramp_code_i, .ilim_i, .out_a_o, .out_b_o, .clk_o
  );

  task automatic check(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d cyc=%0d", tag, act, exp_v, cyc);
    end
  endtask

  function automatic int pos();
    return cyc % (cp + bp);
  endfunction

  task automatic do_reset(input int c, input int b);
    @(negedge clk_i);
    rst_ni = 1'b0;
    chg_len_i = 8'(c);
    blk_len_i = 8'(b);
    sync_i = 1'b0; ilim_i = 1'b0; en_i = 1'b1;
    @(negedge clk_i);
    check("R12 out_a in reset", int'(out_a_o), 0);
    check("R12 out_b in reset", int'(out_b_o), 0);
    check("R12 clk_o in reset", int'(clk_o), 0);
    cp = (c == 0) ? 1 : c;
    bp = (b == 0) ? 1 : b;
    cyc = 0; m_latch = 0; m_steer = 0; m_prev = 0;
    rst_ni = 1'b1;
  endtask

  // inputs already set after a falling edge
  task automatic tick(input string tag);
    bit blank_cur, eff, trip, act, ea, eb;
    blank_cur = (pos() >= cp);
    eff  = blank_cur | (slave_i & sync_i);
    trip = ilim_i | ((int'(ramp_code_i) + OFS) > int'(err_code_i));
    act  = en_i & !eff & !m_latch & !trip;
    ea   = act & !m_steer;
    eb   = act & m_steer;
    m_latch = eff ? 1'b0 : (trip ? 1'b1 : m_latch);
    if (en_i && eff && !m_prev) m_steer = !m_steer;
    m_prev = eff;
    @(posedge clk_i);
    cyc++;
    @(negedge clk_i);
    check({tag, " out_a"}, int'(out_a_o), int'(ea));
    check({tag, " out_b"}, int'(out_b_o), int'(eb));
    check("R1 clk_o", int'(clk_o), int'(pos() >= cp));
    check("R11 exclusive", int'(out_a_o & out_b_o), 0);
  endtask

  task automatic run_ramp(input string tag, input int periods, input int step);
    for (int i = 0; i < periods * (cp + bp); i++) begin
      ramp_code_i = 8'((pos() < cp) ? pos() * step : 0);
      tick(tag);
    end
  endtask

  initial begin
    do_reset(9, 1);
    // R3: full duty, alternation
    err_code_i = 8'd255;
    run_ramp("R3 alternate", 4, 0);
    // R4: threshold sweep, including err below offset
    for (int e = 0; e < 6; e++) begin
      err_code_i = 8'(20 + e * 45);
      run_ramp("R4 compare", 3, 16);
    end
    // R6: trip then ramp falls back within the period
    err_code_i = 8'd100;
    for (int i = 0; i < 4 * (cp + bp); i++) begin
      ramp_code_i = 8'((pos() >= 3 && pos() < 5) ? 200 : 0);
      tick("R6 latch hold");
    end
    // R5: current-limit pulses
    err_code_i = 8'd255; ramp_code_i = 8'd0;
    for (int i = 0; i < 4 * (cp + bp); i++) begin
      ilim_i = (pos() == 4 || pos() == 2 && i > 10);
      tick("R5 ilim");
    end
    ilim_i = 1'b0;
    // R7: slave sync
    slave_i = 1'b1;
    for (int i = 0; i < 4 * (cp + bp); i++) begin
      sync_i = (pos() == 3);
      tick("R7 slave sync");
    end
    // R8: master mode ignores sync
    slave_i = 1'b0;
    for (int i = 0; i < 4 * (cp + bp); i++) begin
      sync_i = (pos() == 3 || pos() == 6);
      tick("R8 master sync");
    end
    sync_i = 1'b0;
    // R9: enable gap spanning blanking
    for (int i = 0; i < 5 * (cp + bp); i++) begin
      en_i = !(i >= 7 && i < 7 + 2 * (cp + bp) + 1);
      tick("R9 enable");
    end
    en_i = 1'b1;
    // R2: other period shape
    do_reset(6, 2);
    err_code_i = 8'd120;
    run_ramp("R2 blanking", 5, 20);
    // R10: zero lengths
    do_reset(0, 0);
    err_code_i = 8'd255;
    run_ramp("R10 zero both", 6, 0);
    do_reset(4, 0);
    run_ramp("R10 zero blank", 5, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule